// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps wall-clock time and date (seconds, minutes, hours, day of week, day of month, month and a two-digit year) and moves it forward by one second each time a one-second strobe arrives. Time is held internally in binary. The seven time bytes seen at the outputs are encoded from it on the fly, in BCD or plain binary and in 24-hour or 12-hour form, as the mode inputs select.

Each advance is announced by an update-in-progress flag. The flag stays high for a fixed number of clock cycles before the new time is published. When the new time appears, an update-ended pulse fires. An interrupt pulse fires with it if update interrupts are enabled. If the alarm is enabled and the new time matches the three alarm bytes, an alarm pulse fires as well. A host halts publishing with the set-mode input and loads time fields through a simple write strobe. Counting resumes from the loaded values once set mode is released.

All pins are plain control and status signals. No stream passes the block's edge, so no valid/ready handshake is used.

Top module: `calendar_clock`

## Requirements
- R1: After reset the time is 00:00:00, day of week 1, day 1, month 1, year 00. The update-in-progress flag is low and no event pulse is active.
- R2: A strobe on `sec_tick` starts an update only when `osc_ctl` equals 3'b010 and `set_mode` is low. Otherwise the strobe is ignored: the flag stays low and the time bytes are unchanged.
- R3: An accepted strobe raises `uip_o` on the next clock edge. The flag stays high for UIP_LEAD cycles. On the edge that lowers it, the new time appears on the outputs and `uf_pulse_o` is high for exactly one cycle.
- R4: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the date. Day of week counts 1 to 7 and then returns to 1.
- R5: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days when BASE_YEAR plus the year field is divisible by 4, and either not divisible by 100 or divisible by 400.
- R6: The day of month returns to 1 after the last day. Month 12 rolls to month 1 and increments the year. Year 99 rolls to 00.
- R7: With `bin_mode` low, every byte is BCD: tens digit in bits 7:4, units in bits 3:0. With `bin_mode` high, every byte is the plain binary value. Writes are decoded in the same mode.
- R8: With `hr24_mode` low, the hours byte carries the hour modulo 12 in bits 6:0, and bit 7 is set for hours 12 to 23. Midnight reads 0x00 and noon reads 0x80. A write whose bit 7 is set adds 12 to the decoded hour.
- R9: While `set_mode` is high, a write with `wr_en` loads the field picked by `wr_sel` (0 sec, 1 min, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year). Raising `set_mode` clears `uip_o` and cancels the pending update. Writes while `set_mode` is low are ignored.
- R10: `irq_pulse_o` fires together with `uf_pulse_o` when `upd_irq_en` is high, and does not fire for an update when it is low (and no alarm hits).
- R11: With `alarm_en` high, `af_pulse_o` and `irq_pulse_o` fire with the update when seconds, minutes and hours, as encoded on the outputs, each equal their alarm byte or have an alarm byte whose bits 7:6 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| osc_ctl | input | 3 | Oscillator control field; 3'b010 lets time run |
| set_mode | input | 1 | Halts publishing and allows writes |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| upd_irq_en | input | 1 | Enables interrupt on update end |
| alarm_en | input | 1 | Enables alarm compare |
| alarm_sec | input | 8 | Alarm seconds byte (bits 7:6 = 11 matches any) |
| alarm_min | input | 8 | Alarm minutes byte |
| alarm_hr | input | 8 | Alarm hours byte |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | Write byte, in the current encoding |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hr_o | output | 8 | Hours byte |
| wday_o | output | 8 | Day-of-week byte |
| mday_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| yr_o | output | 8 | Year byte |
| uip_o | output | 1 | Update-in-progress flag |
| uf_pulse_o | output | 1 | Update-ended pulse |
| af_pulse_o | output | 1 | Alarm pulse |
| irq_pulse_o | output | 1 | Interrupt pulse |

## Verification
The carry chain is exercised with loaded times just before each boundary. These are a plain seconds step, a minute carry, a full year-end rollover, the end of February in a leap year and in a common year, and a 30-day month. Together they separate a wrong wrap limit from a missing carry or a wrong leap rule. The same values are shown in binary and in 12-hour form, with noon and midnight, so the encoders are checked apart from the counters. Alarm cases cover an exact match, a wildcard match and a near miss in a single field. Frozen-oscillator, set-mode and cancelled-update cases confirm that strobes and writes are ignored when they should be.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam int unsigned FIELD_CNT = 7;
  localparam logic [2:0]  OSC_RUN   = 3'b010;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HR   = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YR   = 3'd6
  } cal_field_e;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] encode(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

endpackage

// File: rtl/cal_next_second.sv
module cal_next_second
  import cal_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 2000
) (
  input  cal_time_t cur,
  output cal_time_t nxt
);

  int unsigned full_yr;
  logic        leap;
  logic [4:0]  dim;

  always_comb begin
    full_yr = BASE_YEAR + 32'(cur.yr);
    leap    = (full_yr % 4 == 0) && ((full_yr % 100 != 0) || (full_yr % 400 == 0));
    case (cur.mon)
      4'd2:                      dim = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   dim = 5'd30;
      default:                   dim = 5'd31;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (cur.sec >= 6'd59) begin
      nxt.sec = '0;
      if (cur.min >= 6'd59) begin
        nxt.min = '0;
        if (cur.hr >= 5'd23) begin
          nxt.hr   = '0;
          nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
          if (cur.mday >= dim) begin
            nxt.mday = 5'd1;
            if (cur.mon >= 4'd12) begin
              nxt.mon = 4'd1;
              nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
            end else begin
              nxt.mon = cur.mon + 4'd1;
            end
          end else begin
            nxt.mday = cur.mday + 5'd1;
          end
        end else begin
          nxt.hr = cur.hr + 5'd1;
        end
      end else begin
        nxt.min = cur.min + 6'd1;
      end
    end else begin
      nxt.sec = cur.sec + 6'd1;
    end
  end

endmodule

// File: rtl/cal_format.sv
module cal_format
  import cal_pkg::*;
(
  input  cal_time_t                    t,
  input  logic                         bin_mode,
  input  logic                         hr24_mode,
  output logic [FIELD_CNT-1:0][7:0]    bytes_o
);

  logic       pm;
  logic [6:0] hr12;
  logic [7:0] hr12_enc;

  always_comb begin
    pm       = (t.hr >= 5'd12);
    hr12     = pm ? 7'(t.hr - 5'd12) : 7'(t.hr);
    hr12_enc = encode(hr12, bin_mode);
    bytes_o[F_SEC]  = encode(7'(t.sec), bin_mode);
    bytes_o[F_MIN]  = encode(7'(t.min), bin_mode);
    bytes_o[F_HR]   = hr24_mode ? encode(7'(t.hr), bin_mode) : {pm, hr12_enc[6:0]};
    bytes_o[F_WDAY] = encode(7'(t.wday), bin_mode);
    bytes_o[F_MDAY] = encode(7'(t.mday), bin_mode);
    bytes_o[F_MON]  = encode(7'(t.mon), bin_mode);
    bytes_o[F_YR]   = encode(t.yr, bin_mode);
  end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int unsigned N_FIELDS = 3
) (
  input  logic [N_FIELDS-1:0][7:0] alarm,
  input  logic [N_FIELDS-1:0][7:0] value,
  output logic                     match
);

  logic [N_FIELDS-1:0] hit;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    assign hit[i] = (alarm[i][7:6] == 2'b11) || (alarm[i] == value[i]);
  end

  assign match = &hit;

endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import cal_pkg::*;
#(
  parameter int unsigned UIP_LEAD  = 8,
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_ctl,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       hr24_mode,
  input  logic       upd_irq_en,
  input  logic       alarm_en,
  input  logic [7:0] alarm_sec,
  input  logic [7:0] alarm_min,
  input  logic [7:0] alarm_hr,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic       uip_o,
  output logic       uf_pulse_o,
  output logic       af_pulse_o,
  output logic       irq_pulse_o
);

  localparam int unsigned CNT_W = $clog2(UIP_LEAD + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(UIP_LEAD - 1);

  cal_time_t                     time_q, time_nxt;
  logic [CNT_W-1:0]              cnt_q;
  logic [FIELD_CNT-1:0][7:0]     cur_bytes, nxt_bytes;
  logic                          alarm_hit;
  logic [6:0]                    wr_val, wr_hr;

  cal_next_second #(.BASE_YEAR(BASE_YEAR)) u_next (
    .cur (time_q),
    .nxt (time_nxt)
  );

  cal_format u_fmt_cur (
    .t         (time_q),
    .bin_mode  (bin_mode),
    .hr24_mode (hr24_mode),
    .bytes_o   (cur_bytes)
  );

  cal_format u_fmt_nxt (
    .t         (time_nxt),
    .bin_mode  (bin_mode),
    .hr24_mode (hr24_mode),
    .bytes_o   (nxt_bytes)
  );

  cal_alarm_match #(.N_FIELDS(3)) u_alarm (
    .alarm ({alarm_hr, alarm_min, alarm_sec}),
    .value ({nxt_bytes[F_HR], nxt_bytes[F_MIN], nxt_bytes[F_SEC]}),
    .match (alarm_hit)
  );

  always_comb begin
    wr_val = bin_mode ? wr_data[6:0] : from_bcd(wr_data);
    wr_hr  = bin_mode ? {1'b0, wr_data[5:0]} : from_bcd({1'b0, wr_data[6:0]});
    if (!hr24_mode && wr_data[7]) wr_hr = wr_hr + 7'd12;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q      <= '{yr: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                       hr: 5'd0, min: 6'd0, sec: 6'd0};
      cnt_q       <= '0;
      uip_o       <= 1'b0;
      uf_pulse_o  <= 1'b0;
      af_pulse_o  <= 1'b0;
      irq_pulse_o <= 1'b0;
    end else begin
      uf_pulse_o  <= 1'b0;
      af_pulse_o  <= 1'b0;
      irq_pulse_o <= 1'b0;
      if (set_mode) begin
        uip_o <= 1'b0;
        cnt_q <= '0;
        if (wr_en) begin
          case (cal_field_e'(wr_sel))
            F_SEC:   time_q.sec  <= wr_val[5:0];
            F_MIN:   time_q.min  <= wr_val[5:0];
            F_HR:    time_q.hr   <= wr_hr[4:0];
            F_WDAY:  time_q.wday <= wr_val[2:0];
            F_MDAY:  time_q.mday <= wr_val[4:0];
            F_MON:   time_q.mon  <= wr_val[3:0];
            F_YR:    time_q.yr   <= wr_val;
            default: ;
          endcase
        end
      end else if (uip_o) begin
        if (cnt_q == '0) begin
          time_q      <= time_nxt;
          uip_o       <= 1'b0;
          uf_pulse_o  <= 1'b1;
          af_pulse_o  <= alarm_en & alarm_hit;
          irq_pulse_o <= upd_irq_en | (alarm_en & alarm_hit);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (sec_tick && osc_ctl == OSC_RUN) begin
        uip_o <= 1'b1;
        cnt_q <= CNT_LOAD;
      end
    end
  end

  assign sec_o  = cur_bytes[F_SEC];
  assign min_o  = cur_bytes[F_MIN];
  assign hr_o   = cur_bytes[F_HR];
  assign wday_o = cur_bytes[F_WDAY];
  assign mday_o = cur_bytes[F_MDAY];
  assign mon_o  = cur_bytes[F_MON];
  assign yr_o   = cur_bytes[F_YR];

endmodule

// File: rtl/calendar_clock_chk.sv
module calendar_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic [2:0] osc_ctl,
  input logic       set_mode,
  input logic       alarm_en,
  input logic       uip_o,
  input logic       uf_pulse_o,
  input logic       af_pulse_o,
  input logic       irq_pulse_o
);

  a_r2_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_o) |-> ($past(osc_ctl) == 3'b010 && !$past(set_mode) && $past(sec_tick)));

  a_r9_set_drops_uip: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |=> !uip_o);

  a_r3_publish_ends_window: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse_o |-> ($past(uip_o) && !uip_o));

  a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> uf_pulse_o);

  a_r11_alarm_at_update: assert property (@(posedge clk) disable iff (!rst_n)
    af_pulse_o |-> (uf_pulse_o && $past(alarm_en) && irq_pulse_o));

endmodule

bind calendar_clock calendar_clock_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .osc_ctl     (osc_ctl),
  .set_mode    (set_mode),
  .alarm_en    (alarm_en),
  .uip_o       (uip_o),
  .uf_pulse_o  (uf_pulse_o),
  .af_pulse_o  (af_pulse_o),
  .irq_pulse_o (irq_pulse_o)
);

// File: tb/calendar_clock_tb_top.sv
module calendar_clock_tb_top;

  localparam int unsigned LEAD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [2:0] osc_ctl = 3'b000;
  logic       set_mode = 1'b0;
  logic       bin_mode = 1'b0;
  logic       hr24_mode = 1'b1;
  logic       upd_irq_en = 1'b0;
  logic       alarm_en = 1'b0;
  logic [7:0] alarm_sec = 8'h00, alarm_min = 8'h00, alarm_hr = 8'h00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hr_o, wday_o, mday_o, mon_o, yr_o;
  logic       uip_o, uf_pulse_o, af_pulse_o, irq_pulse_o;

  always #2 clk = ~clk;

  calendar_clock #(.UIP_LEAD(LEAD), .BASE_YEAR(2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ctl(osc_ctl),
    .set_mode(set_mode), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
    .upd_irq_en(upd_irq_en), .alarm_en(alarm_en), .alarm_sec(alarm_sec),
    .alarm_min(alarm_min), .alarm_hr(alarm_hr), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .yr_o(yr_o),
    .uip_o(uip_o), .uf_pulse_o(uf_pulse_o), .af_pulse_o(af_pulse_o),
    .irq_pulse_o(irq_pulse_o)
  );

  typedef struct {
    logic [55:0] tbytes;
    logic        af;
    logic        irq;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  function automatic logic [55:0] cur_bytes();
    return {yr_o, mon_o, mday_o, wday_o, hr_o, min_o, sec_o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per published update
  always @(negedge clk) begin
    if (rst_n && uf_pulse_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected update", 64'(cur_bytes()), 64'd0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(cur_bytes() == it.tbytes && af_pulse_o == it.af && irq_pulse_o == it.irq,
              it.tag, {6'd0, af_pulse_o, irq_pulse_o, cur_bytes()},
              {6'd0, it.af, it.irq, it.tbytes});
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    sec_tick = 1'b1;
    step();
    sec_tick = 1'b0;
  endtask

  task automatic expect_update(input logic [55:0] tb, input logic af, input logic irq, input string tag);
    sb_item_t it;
    it.tbytes = tb; it.af = af; it.irq = irq; it.tag = tag;
    sb_q.push_back(it);
    pulse_tick();
    step(LEAD + 2);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo,
                      input logic [7:0] y);
    set_mode = 1'b1;
    step();
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd);
    wr(3'd4, md); wr(3'd5, mo); wr(3'd6, y);
    set_mode = 1'b0;
    step();
  endtask

  // bytes packed as {yr, mon, mday, wday, hr, min, sec}
  function automatic logic [55:0] tv(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] md,
                                     input logic [7:0] wd, input logic [7:0] h, input logic [7:0] m,
                                     input logic [7:0] s);
    return {y, mo, md, wd, h, m, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [55:0] snap;
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(cur_bytes() == tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R1 reset time",
          64'(cur_bytes()), 64'(tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00)));
    check(!uip_o && !uf_pulse_o && !af_pulse_o && !irq_pulse_o, "R1 reset flags",
          {60'd0, uip_o, uf_pulse_o, af_pulse_o, irq_pulse_o}, 64'd0);

    // R2 frozen oscillator values ignore the strobe
    osc_ctl = 3'b000;
    pulse_tick();
    check(!uip_o, "R2 uip with osc 000", 64'(uip_o), 64'd0);
    step(LEAD + 4);
    check(sec_o == 8'h00, "R2 time frozen osc 000", 64'(sec_o), 64'h00);
    osc_ctl = 3'b110;
    pulse_tick();
    step(LEAD + 4);
    check(sec_o == 8'h00 && !uip_o, "R2 time frozen osc 110", 64'(sec_o), 64'h00);
    osc_ctl = 3'b010;

    // R3 window length and publish point
    begin
      sb_item_t it;
      bit ok;
      it.tbytes = tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01);
      it.af = 1'b0; it.irq = 1'b0; it.tag = "R3 first second";
      sb_q.push_back(it);
      pulse_tick();
      ok = 1'b1;
      for (int i = 0; i < LEAD; i++) begin
        if (!uip_o || sec_o != 8'h00) ok = 1'b0;
        if (i < LEAD - 1) step();
      end
      check(ok, "R3 uip high for lead cycles, old time held", 64'(sec_o), 64'h00);
      step();
      check(!uip_o && uf_pulse_o && sec_o == 8'h01, "R3 publish as uip falls",
            {55'd0, uip_o, uf_pulse_o, sec_o}, {55'd0, 1'b0, 1'b1, 8'h01});
      step();
      check(!uf_pulse_o, "R3 uf lasts one cycle", 64'(uf_pulse_o), 64'd0);
      step(2);
    end

    // R4 R6 full year-end rollover
    load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    expect_update(tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 1'b0, 1'b0, "R6 year end rollover");
    load(8'h59, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h25);
    expect_update(tv(8'h25, 8'h06, 8'h15, 8'h03, 8'h12, 8'h35, 8'h00), 1'b0, 1'b0, "R4 minute carry");
    load(8'h59, 8'h59, 8'h22, 8'h05, 8'h10, 8'h03, 8'h10);
    expect_update(tv(8'h10, 8'h03, 8'h10, 8'h05, 8'h23, 8'h00, 8'h00), 1'b0, 1'b0, "R4 hour carry");

    // R5 month lengths and leap years
    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    expect_update(tv(8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00), 1'b0, 1'b0, "R5 leap year 2000 feb 29");
    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h01);
    expect_update(tv(8'h01, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), 1'b0, 1'b0, "R5 common year feb 28");
    load(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    expect_update(tv(8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00), 1'b0, 1'b0, "R5 leap feb 29 end");
    load(8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h04, 8'h24);
    expect_update(tv(8'h24, 8'h05, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00), 1'b0, 1'b0, "R5 thirty day month");

    // R7 binary encoding
    bin_mode = 1'b1;
    load(8'h3B, 8'h3B, 8'h0A, 8'h04, 8'h1F, 8'h07, 8'h63);
    expect_update(tv(8'h63, 8'h07, 8'h1F, 8'h04, 8'h0B, 8'h00, 8'h00), 1'b0, 1'b0, "R7 binary update");
    bin_mode = 1'b0;
    step();
    check(cur_bytes() == tv(8'h99, 8'h07, 8'h31, 8'h04, 8'h11, 8'h00, 8'h00), "R7 same time in BCD",
          64'(cur_bytes()), 64'(tv(8'h99, 8'h07, 8'h31, 8'h04, 8'h11, 8'h00, 8'h00)));

    // R8 12-hour form
    hr24_mode = 1'b0;
    load(8'h59, 8'h59, 8'h91, 8'h01, 8'h05, 8'h05, 8'h20);
    expect_update(tv(8'h20, 8'h05, 8'h06, 8'h02, 8'h00, 8'h00, 8'h00), 1'b0, 1'b0, "R8 11pm to midnight");
    load(8'h59, 8'h59, 8'h11, 8'h01, 8'h05, 8'h05, 8'h20);
    expect_update(tv(8'h20, 8'h05, 8'h05, 8'h01, 8'h80, 8'h00, 8'h00), 1'b0, 1'b0, "R8 11am to noon");
    hr24_mode = 1'b1;
    step();
    check(hr_o == 8'h12, "R8 noon in 24h form", 64'(hr_o), 64'h12);

    // R9 writes ignored outside set mode; set mode cancels an update
    snap = cur_bytes();
    wr(3'd0, 8'h30);
    step();
    check(cur_bytes() == snap, "R9 write ignored when set low", 64'(cur_bytes()), 64'(snap));
    pulse_tick();
    step(2);
    set_mode = 1'b1;
    step();
    check(!uip_o, "R9 set clears uip", 64'(uip_o), 64'd0);
    step(LEAD + 4);
    set_mode = 1'b0;
    step();
    check(cur_bytes() == snap, "R9 cancelled update leaves time", 64'(cur_bytes()), 64'(snap));
    set_mode = 1'b1;
    pulse_tick();
    step(LEAD + 4);
    set_mode = 1'b0;
    step();
    check(cur_bytes() == snap && !uip_o, "R2 strobe ignored in set mode", 64'(cur_bytes()), 64'(snap));

    // R10 update interrupt
    upd_irq_en = 1'b1;
    expect_update(tv(8'h20, 8'h05, 8'h05, 8'h01, 8'h12, 8'h00, 8'h01), 1'b0, 1'b1, "R10 irq with uie");
    upd_irq_en = 1'b0;
    expect_update(tv(8'h20, 8'h05, 8'h05, 8'h01, 8'h12, 8'h00, 8'h02), 1'b0, 1'b0, "R10 no irq without uie");

    // R11 alarm compare
    alarm_en = 1'b1;
    alarm_sec = 8'h15; alarm_min = 8'hC0; alarm_hr = 8'hC0;
    load(8'h14, 8'h30, 8'h08, 8'h02, 8'h09, 8'h09, 8'h09);
    expect_update(tv(8'h09, 8'h09, 8'h09, 8'h02, 8'h08, 8'h30, 8'h15), 1'b1, 1'b1, "R11 wildcard match");
    expect_update(tv(8'h09, 8'h09, 8'h09, 8'h02, 8'h08, 8'h30, 8'h16), 1'b0, 1'b0, "R11 seconds miss");
    alarm_sec = 8'hC5; alarm_min = 8'h30; alarm_hr = 8'h08;
    expect_update(tv(8'h09, 8'h09, 8'h09, 8'h02, 8'h08, 8'h30, 8'h17), 1'b1, 1'b1, "R11 exact min hr match");
    alarm_hr = 8'h09;
    expect_update(tv(8'h09, 8'h09, 8'h09, 8'h02, 8'h08, 8'h30, 8'h18), 1'b0, 1'b0, "R11 hour miss");
    alarm_en = 1'b0; alarm_hr = 8'h08;
    expect_update(tv(8'h09, 8'h09, 8'h09, 8'h02, 8'h08, 8'h30, 8'h19), 1'b0, 1'b0, "R11 alarm disabled");

    step(4);
    check(sb_q.size() == 0, "R3 every expected update published", 64'(sb_q.size()), 64'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule